// File: doc/BRIEF.md
# Cache invalidation sequencer

This block sequences the control side of an instruction cache. It holds the cache enable, the associativity mode and a software invalidate request. It runs a sweep that clears every tag line, visiting one line index per clock and raising a valid-clear strobe with that index. While a sweep is running, the lookup path is told not to serve hits. A sweep starts on its own when reset is released and whenever the enable is turned off. Software can also request one.

Two sticky flags report status: sweep-complete and bus error. Each flag is cleared by writing one to its bit in a clear port. Each flag has its own interrupt enable, and a single interrupt output combines them. The mode can be changed only while the cache is off. A mode write made while the cache is on is dropped.

Top module: `cache_sweep_ctl`

## Requirements
- R1: While reset is asserted and on release, a sweep is in progress (`busy_o`=1, index 0), enable is 0, the mode reads two-way (`twoway_o`=1), both flags and both interrupt enables are 0, and `lookup_en_o` is 0.
- R2: While busy, `wipe_vld_o` is high and `wipe_idx_o` advances by one each clock from 0 to LINES-1. Busy lasts exactly LINES cycles.
- R3: In the cycle after the sweep shows index LINES-1, busy is 0 and the sweep-complete flag `done_o` is 1. The flag stays set until it is cleared.
- R4: A clear-port write with `clr_done_i`=1 clears `done_o`. A clear-port write with `clr_done_i`=0 leaves it unchanged.
- R5: A control write with `ctl_en_i`=0 while enabled and idle starts a sweep at index 0 in the next cycle. The same write made while already disabled starts nothing.
- R6: A control write with `ctl_inv_i`=1 made while idle shows `inv_req_o`=1 for exactly one cycle, and the sweep then starts. The same write made during a sweep is ignored: `inv_req_o` stays 0 and the sweep length is unchanged.
- R7: A control write made while disabled loads `twoway_o` from `ctl_twoway_i` (1 = two-way, 0 = direct-mapped). A control write made while enabled leaves `twoway_o` unchanged.
- R8: A control write may set the enable at any time. `lookup_en_o` is 1 only when enabled and not busy.
- R9: A one-cycle `err_pulse_i` sets `err_o` in the next cycle. It stays set until a clear-port write with `clr_err_i`=1.
- R10: An enable-port write loads both interrupt enables. `irq_o` is high whenever a flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ctl_we | input | 1 | control word write strobe |
| ctl_en_i | input | 1 | enable value written |
| ctl_twoway_i | input | 1 | mode value written (1 two-way) |
| ctl_inv_i | input | 1 | invalidate request written |
| clr_we | input | 1 | flag-clear write strobe |
| clr_done_i | input | 1 | write one to clear sweep-complete flag |
| clr_err_i | input | 1 | write one to clear error flag |
| ie_we | input | 1 | interrupt-enable write strobe |
| ie_done_i | input | 1 | sweep-complete interrupt enable value |
| ie_err_i | input | 1 | error interrupt enable value |
| err_pulse_i | input | 1 | one-cycle bus error indication |
| en_o | output | 1 | cache enable |
| twoway_o | output | 1 | associativity mode |
| inv_req_o | output | 1 | pending invalidate request |
| busy_o | output | 1 | sweep in progress |
| done_o | output | 1 | sweep-complete flag |
| err_o | output | 1 | error flag |
| ie_done_o | output | 1 | sweep-complete interrupt enable |
| ie_err_o | output | 1 | error interrupt enable |
| irq_o | output | 1 | combined interrupt |
| lookup_en_o | output | 1 | hits may be served |
| wipe_vld_o | output | 1 | valid-clear strobe |
| wipe_idx_o | output | $clog2(LINES) | line index being cleared |

## Verification
The assertions check the following on every cycle:
- the sweep index steps by one and ends with the complete flag set;
- a disable write starts a sweep;
- the invalidate request lasts exactly one cycle;
- a mode write made while enabled changes nothing;
- both flags are sticky, and a busy sweep blocks hits.

Other behaviour needs the bench's scenarios:
- a sweep lasts exactly LINES cycles;
- an invalidate issued mid-sweep is ignored;
- a repeated disable starts no sweep;
- enabling during a sweep withholds hits until the sweep ends;
- the interrupt output combines each flag with its enable.

The bench covers these with a cycle model compared on every clock.

// File: rtl/sweep_ctl_pkg.sv
package sweep_ctl_pkg;
  typedef struct packed {
    logic en;
    logic twoway;
    logic inv;
  } ctl_word_t;

  localparam int FLG_DONE = 0;
  localparam int FLG_ERR  = 1;
  localparam int NFLAGS   = 2;
endpackage

// File: rtl/sc_ctl_regs.sv
module sc_ctl_regs
  import sweep_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_we,
  input  ctl_word_t wr,
  input  logic      busy,
  output logic      en,
  output logic      twoway,
  output logic      inv_req,
  output logic      start_req
);
  logic en_q, en_d, tw_q, tw_d, inv_q, inv_d;
  logic disable_evt;

  // turning the enable off triggers a sweep
  assign disable_evt = ctl_we & en_q & ~wr.en;

  always_comb begin
    en_d  = en_q;
    tw_d  = tw_q;
    if (ctl_we) begin
      en_d = wr.en;
      if (!en_q) tw_d = wr.twoway;   // mode locked while enabled
    end
    // request held one cycle, then consumed by the sweep engine
    inv_d = ~inv_q & ctl_we & wr.inv & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tw_q  <= 1'b1;
      inv_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        en_q <= en_d;
        tw_q <= tw_d;
      end
      if (inv_q | ctl_we) inv_q <= inv_d;
    end
  end

  assign en        = en_q;
  assign twoway    = tw_q;
  assign inv_req   = inv_q;
  assign start_req = disable_evt | inv_q;
endmodule

// File: rtl/sc_sweep.sv
module sc_sweep #(
  parameter int LINES = 64,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          finish
);
  localparam logic [IW-1:0] LAST = IW'(LINES - 1);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          advance;

  assign finish  = busy_q & (idx_q == LAST);
  assign advance = busy_q | start;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      if (finish) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + IW'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  // a sweep is already running out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (advance) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
endmodule

// File: rtl/sc_flags.sv
module sc_flags
  import sweep_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_v,
  input  logic              clr_we,
  input  logic [NFLAGS-1:0] clr_v,
  input  logic              ie_we,
  input  logic [NFLAGS-1:0] ie_v,
  output logic [NFLAGS-1:0] flags,
  output logic [NFLAGS-1:0] ie,
  output logic              irq
);
  logic [NFLAGS-1:0] flg_q, flg_d, ie_q;

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    // a set in the same cycle wins over a clear
    assign flg_d[g] = set_v[g] | (flg_q[g] & ~(clr_we & clr_v[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ie_q  <= '0;
    end else begin
      flg_q <= flg_d;
      if (ie_we) ie_q <= ie_v;
    end
  end

  assign flags = flg_q;
  assign ie    = ie_q;
  assign irq   = |(flg_q & ie_q);
endmodule

// File: rtl/cache_sweep_ctl.sv
module cache_sweep_ctl
  import sweep_ctl_pkg::*;
#(
  parameter int LINES = 64,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_en_i,
  input  logic          ctl_twoway_i,
  input  logic          ctl_inv_i,
  input  logic          clr_we,
  input  logic          clr_done_i,
  input  logic          clr_err_i,
  input  logic          ie_we,
  input  logic          ie_done_i,
  input  logic          ie_err_i,
  input  logic          err_pulse_i,
  output logic          en_o,
  output logic          twoway_o,
  output logic          inv_req_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          ie_done_o,
  output logic          ie_err_o,
  output logic          irq_o,
  output logic          lookup_en_o,
  output logic          wipe_vld_o,
  output logic [IW-1:0] wipe_idx_o
);
  ctl_word_t         wr;
  logic              busy, finish, start_req, en;
  logic [IW-1:0]     idx;
  logic [NFLAGS-1:0] set_v, clr_v, ie_v, flags, ie;

  assign wr = '{en: ctl_en_i, twoway: ctl_twoway_i, inv: ctl_inv_i};

  sc_ctl_regs u_regs (
    .clk, .rst_n, .ctl_we, .wr, .busy,
    .en, .twoway(twoway_o), .inv_req(inv_req_o), .start_req
  );

  sc_sweep #(.LINES(LINES)) u_sweep (
    .clk, .rst_n, .start(start_req), .busy, .idx, .finish
  );

  always_comb begin
    set_v = '0; clr_v = '0; ie_v = '0;
    set_v[FLG_DONE] = finish;
    set_v[FLG_ERR]  = err_pulse_i;
    clr_v[FLG_DONE] = clr_done_i;
    clr_v[FLG_ERR]  = clr_err_i;
    ie_v[FLG_DONE]  = ie_done_i;
    ie_v[FLG_ERR]   = ie_err_i;
  end

  sc_flags u_flags (
    .clk, .rst_n, .set_v, .clr_we, .clr_v, .ie_we, .ie_v,
    .flags, .ie, .irq(irq_o)
  );

  assign en_o        = en;
  assign busy_o      = busy;
  assign done_o      = flags[FLG_DONE];
  assign err_o       = flags[FLG_ERR];
  assign ie_done_o   = ie[FLG_DONE];
  assign ie_err_o    = ie[FLG_ERR];
  assign lookup_en_o = en & ~busy;
  assign wipe_vld_o  = busy;
  assign wipe_idx_o  = idx;
endmodule

// File: rtl/cache_sweep_ctl_chk.sv
module cache_sweep_ctl_chk #(
  parameter int LINES = 64,
  localparam int IW = $clog2(LINES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic          ctl_en_i,
  input logic          clr_we,
  input logic          clr_done_i,
  input logic          clr_err_i,
  input logic          err_pulse_i,
  input logic          en_o,
  input logic          twoway_o,
  input logic          inv_req_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          lookup_en_o,
  input logic [IW-1:0] wipe_idx_o
);
  localparam logic [IW-1:0] LAST = IW'(LINES - 1);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && wipe_idx_o != LAST |=> busy_o && wipe_idx_o == $past(wipe_idx_o) + IW'(1));

  // R3
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && wipe_idx_o == LAST |=> !busy_o && done_o);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !(clr_we && clr_done_i) |=> done_o);

  // R5
  disable_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && en_o && !ctl_en_i && !busy_o |=> busy_o && wipe_idx_o == '0 && !en_o);

  // R6
  inv_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_req_o |=> !inv_req_o && busy_o);

  // R7
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && en_o |=> $stable(twoway_o));

  // R8
  no_hit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !lookup_en_o);

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_i |=> err_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o && !(clr_we && clr_err_i) |=> err_o);
endmodule

bind cache_sweep_ctl cache_sweep_ctl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en_i(ctl_en_i),
  .clr_we(clr_we), .clr_done_i(clr_done_i), .clr_err_i(clr_err_i),
  .err_pulse_i(err_pulse_i), .en_o(en_o), .twoway_o(twoway_o),
  .inv_req_o(inv_req_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .lookup_en_o(lookup_en_o), .wipe_idx_o(wipe_idx_o)
);

// File: tb/cache_sweep_ctl_test.sv
`timescale 1ns/1ps
module cache_sweep_ctl_test;
  localparam int LINES = 16;
  localparam int IW = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0, ctl_en_i = 0, ctl_twoway_i = 0, ctl_inv_i = 0;
  logic clr_we = 0, clr_done_i = 0, clr_err_i = 0;
  logic ie_we = 0, ie_done_i = 0, ie_err_i = 0, err_pulse_i = 0;
  logic en_o, twoway_o, inv_req_o, busy_o, done_o, err_o, ie_done_o, ie_err_o;
  logic irq_o, lookup_en_o, wipe_vld_o;
  logic [IW-1:0] wipe_idx_o;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit over = 0;

  always #2.5 clk = ~clk;

  cache_sweep_ctl #(.LINES(LINES)) uut (.*);

  // behavioural reference model
  bit m_en, m_tw, m_inv, m_busy, m_done, m_err, m_ied, m_iee;
  int m_idx;
  wire m_fin   = m_busy && (m_idx == LINES - 1);
  wire m_start = (ctl_we && m_en && !ctl_en_i) || m_inv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_tw <= 1; m_inv <= 0; m_busy <= 1; m_idx <= 0;
      m_done <= 0; m_err <= 0; m_ied <= 0; m_iee <= 0;
    end else begin
      if (ctl_we) begin
        m_en <= ctl_en_i;
        if (!m_en) m_tw <= ctl_twoway_i;
      end
      m_inv <= !m_inv && ctl_we && ctl_inv_i && !m_busy;
      if (m_busy) begin
        m_busy <= !m_fin;
        m_idx  <= m_fin ? 0 : m_idx + 1;
      end else if (m_start) begin
        m_busy <= 1; m_idx <= 0;
      end
      m_done <= m_fin || (m_done && !(clr_we && clr_done_i));
      m_err  <= err_pulse_i || (m_err && !(clr_we && clr_err_i));
      if (ie_we) begin m_ied <= ie_done_i; m_iee <= ie_err_i; end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("R2", "busy", busy_o, m_busy);
    chk("R2", "wipe_vld", wipe_vld_o, m_busy);
    chk("R2", "wipe_idx", wipe_idx_o, m_idx);
    chk("R3", "done", done_o, m_done);
    chk("R5", "en", en_o, m_en);
    chk("R6", "inv_req", inv_req_o, m_inv);
    chk("R7", "twoway", twoway_o, m_tw);
    chk("R8", "lookup", lookup_en_o, m_en && !m_busy);
    chk("R9", "err", err_o, m_err);
    chk("R10", "ie_done", ie_done_o, m_ied);
    chk("R10", "ie_err", ie_err_o, m_iee);
    chk("R10", "irq", irq_o, (m_done && m_ied) || (m_err && m_iee));
  end

  task automatic finish_run();
    if (!over) begin
      over = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wr_ctl(input bit en, input bit tw, input bit inv);
    @(negedge clk);
    ctl_we = 1; ctl_en_i = en; ctl_twoway_i = tw; ctl_inv_i = inv;
    @(negedge clk);
    ctl_we = 0; ctl_en_i = 0; ctl_twoway_i = 0; ctl_inv_i = 0;
  endtask

  task automatic wr_clr(input bit d, input bit e);
    @(negedge clk);
    clr_we = 1; clr_done_i = d; clr_err_i = e;
    @(negedge clk);
    clr_we = 0; clr_done_i = 0; clr_err_i = 0;
  endtask

  task automatic wr_ie(input bit d, input bit e);
    @(negedge clk);
    ie_we = 1; ie_done_i = d; ie_err_i = e;
    @(negedge clk);
    ie_we = 0; ie_done_i = 0; ie_err_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * LINES && busy_o; i++) @(negedge clk);
  endtask

  initial begin
    running = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy in reset", busy_o, 1);
    chk("R1", "idx in reset", wipe_idx_o, 0);
    chk("R1", "en in reset", en_o, 0);
    chk("R1", "mode in reset", twoway_o, 1);
    chk("R1", "flags in reset", {done_o, err_o, ie_done_o, ie_err_o}, 0);
    chk("R1", "lookup in reset", lookup_en_o, 0);
    rst_n = 1;
    wait_idle();
    chk("R3", "done after boot sweep", done_o, 1);

    // R4 clear semantics
    wr_clr(0, 1);
    chk("R4", "done kept on zero write", done_o, 1);
    wr_clr(1, 0);
    chk("R4", "done cleared", done_o, 0);

    // R7 R8 enable with direct-mapped
    wr_ctl(1, 0, 0);
    chk("R7", "mode loaded while off", twoway_o, 0);
    chk("R8", "lookup when enabled idle", lookup_en_o, 1);
    wr_ctl(1, 1, 0);
    chk("R7", "mode locked while on", twoway_o, 0);

    // R6 software invalidate
    wr_ctl(1, 0, 1);
    chk("R6", "request visible", inv_req_o, 1);
    chk("R6", "not yet busy", busy_o, 0);
    @(negedge clk);
    chk("R6", "request self-cleared", inv_req_o, 0);
    chk("R6", "sweep started", busy_o, 1);
    chk("R8", "no hits while busy", lookup_en_o, 0);
    begin
      int n = 1;
      ctl_we = 1; ctl_en_i = 1; ctl_inv_i = 1;
      @(negedge clk);
      n++;
      ctl_we = 0; ctl_en_i = 0; ctl_inv_i = 0;
      chk("R6", "request ignored while busy", inv_req_o, 0);
      while (busy_o && n < 4 * LINES) begin
        @(negedge clk);
        if (busy_o) n++;
      end
      chk("R2", "sweep length", n, LINES);
    end
    chk("R8", "hits after sweep", lookup_en_o, 1);
    chk("R3", "done after invalidate", done_o, 1);
    wr_clr(1, 0);

    // R5 disable triggers sweep
    wr_ctl(0, 0, 0);
    chk("R5", "sweep on disable", busy_o, 1);
    chk("R5", "sweep from index 0", wipe_idx_o, 0);
    wait_idle();
    wr_clr(1, 0);
    wr_ctl(0, 0, 0);
    chk("R5", "no sweep on repeated disable", busy_o, 0);

    // R8 enable during a sweep
    wr_ctl(0, 1, 1);
    @(negedge clk);
    ctl_we = 1; ctl_en_i = 1; ctl_twoway_i = 1;
    @(negedge clk);
    ctl_we = 0; ctl_en_i = 0; ctl_twoway_i = 0;
    chk("R8", "enabled during sweep", en_o, 1);
    chk("R8", "hits withheld during sweep", lookup_en_o, 0);
    wait_idle();
    chk("R8", "hits after sweep ends", lookup_en_o, 1);
    chk("R7", "mode two-way", twoway_o, 1);

    // R9 R10 flags and interrupt
    wr_ie(1, 0);
    chk("R10", "irq from done", irq_o, 1);
    wr_clr(1, 0);
    chk("R10", "irq gone", irq_o, 0);
    @(negedge clk);
    err_pulse_i = 1;
    @(negedge clk);
    err_pulse_i = 0;
    chk("R9", "error set", err_o, 1);
    chk("R10", "masked error", irq_o, 0);
    repeat (3) @(negedge clk);
    chk("R9", "error sticky", err_o, 1);
    wr_ie(0, 1);
    chk("R10", "irq from error", irq_o, 1);
    wr_clr(0, 1);
    chk("R9", "error cleared", err_o, 0);
    chk("R10", "irq low", irq_o, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule